// File: doc/BRIEF.md
# Guarded 40-bit DSP Arithmetic Unit with Status Flags

This block performs the four arithmetic operations of a DSP datapath on 40-bit operands: add, subtract, negate and absolute value. Each operand has a 32-bit main part in bits 31..0 and eight guard bits in bits 39..32. The guard bits absorb growth beyond the main part, so a 40-bit result can exceed the 32-bit range without wrapping. The result is registered and presented with a one-cycle write strobe. A status register holds five flags: a selectable decision flag (DC), negative (N), zero (Z), signed overflow (V) and greater-than-zero (GT).

The DC flag reports the carry or borrow at the boundary between the main part and the guard bits. A carry that leaves only the top guard bit does not set it. An operation may be marked conditional. A conditional operation whose condition holds writes its result but leaves every flag alone. A conditional operation whose condition fails does nothing at all. An unconditional operation always writes its result and refreshes the flags. A 3-bit mode input chooses what DC means. This block implements only the carry/borrow meaning, and every mode code selects it.

Top module: `dsp_flag_alu`

## Requirements
- R1: With `op_valid` high, opcode 2'b00 yields `opa + opb` and opcode 2'b01 yields `opa - opb`, both taken modulo 2^40. The value appears on `res` one clock edge later.
- R2: Opcode 2'b10 yields the two's complement negation of `opa` modulo 2^40. Opcode 2'b11 yields `opa` when bit 39 is 0, and otherwise its negation. The absolute value of 0x80_0000_0000 is 0x80_0000_0000 itself.
- R3: For an add, DC is set exactly when the sum of the two operands' bits 31..0 produces a carry into bit 32. A carry out of bit 39 alone leaves DC clear.
- R4: For a subtract, DC is set exactly when bits 31..0 of `opa`, taken as unsigned, are less than bits 31..0 of `opb`. This is a borrow at bit 32.
- R5: A negate, or an absolute value of an input with bit 39 set, is formed as inverted input plus one. DC is the carry that this +1 pushes out of bit 31, so it is set exactly when bits 31..0 of the input are zero. An absolute value of an input with bit 39 clear gives DC = 0.
- R6: N equals result bit 39. Z is set when all 40 result bits are zero. GT is set when both N and Z are clear.
- R7: V is set when the true signed result of the 40-bit operation lies outside the range -2^39 to 2^39-1.
- R8: A valid operation with `cond_op` low writes the result (`res_we` high for exactly one cycle) and loads all five flags from that result. The flags hold whenever no such operation occurs.
- R9: A valid operation with `cond_op` high and `cond_true` high writes the result but leaves all five flags unchanged.
- R10: A valid operation with `cond_op` high and `cond_true` low leaves `res_we` low, leaves `res` unchanged and leaves all flags unchanged.
- R11: After a synchronous active-low reset, `res` is zero, `res_we` is low and all five flags are zero.
- R12: Every value of the 3-bit `dc_mode` input selects carry/borrow meaning for DC, and the results match R3 to R5 for each code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 2 | 00 add, 01 subtract, 10 negate, 11 absolute value |
| opa | input | 40 | First operand (bits 39..32 guard, 31..0 main) |
| opb | input | 40 | Second operand, used by add and subtract |
| cond_op | input | 1 | Marks the operation as conditional |
| cond_true | input | 1 | Condition result for a conditional operation |
| dc_mode | input | 3 | Selects the meaning of DC (all codes: carry/borrow) |
| res | output | 40 | Registered result |
| res_we | output | 1 | One-cycle write strobe for `res` |
| flag_dc | output | 1 | Carry/borrow at main-part MSB |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Signed 40-bit overflow |
| flag_gt | output | 1 | Result greater than zero |

## Verification
Directed operand pairs first separate a carry at the main/guard boundary from a carry that leaves only the guard bits, for both addition and subtraction. These pairs show whether DC is taken from bit 32 or from bit 40. Negate and absolute-value cases cover zero, a zero main part under nonzero guard bits, and the most negative value. These cases tell the +1 carry apart from a plain sign test, and overflow apart from an ordinary result. Random operands with random qualifiers and random mode codes then mix all three write/flag paths. This shows that conditional operations move the result without moving the flags, and that no mode code changes DC.

// File: rtl/dsp_alu_pkg.sv
// Package: shared operation codes and the status flag record for the
// guarded DSP arithmetic unit. Assumes a 2-bit opcode field.
package dsp_alu_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_NEG = 2'b10,
        ALU_ABS = 2'b11
    } alu_op_e;

    typedef enum logic [0:0] {
        DC_CARRY_BORROW = 1'b0
    } dc_meaning_e;

    typedef struct packed {
        logic dc;
        logic n;
        logic z;
        logic v;
        logic gt;
    } dsp_flags_t;

    localparam int unsigned FLAG_CNT = 5;

endpackage

// File: rtl/dsp_alu_core.sv
// Module: dsp_alu_core
// Purely combinational arithmetic for 40-bit guarded operands. Produces
// the modulo-2^DATA_W result, the carry/borrow seen at the boundary between
// the main part and the guard bits, and signed overflow of the full width.
// Assumes MAIN_W >= 2 and GUARD_W >= 1.
module dsp_alu_core
    import dsp_alu_pkg::*;
#(
    parameter int unsigned MAIN_W  = 32,
    parameter int unsigned GUARD_W = 8,
    localparam int unsigned DATA_W = MAIN_W + GUARD_W
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   result,
    output logic                bnd_carry,
    output logic                ovf
);

    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [MAIN_W-1:0] a_main;
    logic [MAIN_W-1:0] b_main;
    logic [DATA_W-1:0] a_inv_inc;
    logic              a_main_zero;
    logic              a_neg;

    // Split operands and precompute the inverted-plus-one form.
    always_comb begin
        a_main      = a[MAIN_W-1:0];
        b_main      = b[MAIN_W-1:0];
        a_inv_inc   = ~a + {{(DATA_W-1){1'b0}}, 1'b1};
        a_main_zero = (a_main == '0);
        a_neg       = a[DATA_W-1];
    end

    // Select the result, boundary carry and overflow for each operation.
    always_comb begin
        result    = '0;
        bnd_carry = 1'b0;
        ovf       = 1'b0;
        unique case (op)
            ALU_ADD: begin
                result    = a + b;
                bnd_carry = (result[MAIN_W-1:0] < a_main);
                ovf       = (a[DATA_W-1] == b[DATA_W-1]) &&
                            (result[DATA_W-1] != a[DATA_W-1]);
            end
            ALU_SUB: begin
                result    = a - b;
                bnd_carry = (a_main < b_main);
                ovf       = (a[DATA_W-1] != b[DATA_W-1]) &&
                            (result[DATA_W-1] != a[DATA_W-1]);
            end
            ALU_NEG: begin
                result    = a_inv_inc;
                bnd_carry = a_main_zero;
                ovf       = (a == MOST_NEG);
            end
            ALU_ABS: begin
                if (a_neg) begin
                    result    = a_inv_inc;
                    bnd_carry = a_main_zero;
                    ovf       = (a == MOST_NEG);
                end else begin
                    result    = a;
                    bnd_carry = 1'b0;
                    ovf       = 1'b0;
                end
            end
            default: begin
                result    = '0;
                bnd_carry = 1'b0;
                ovf       = 1'b0;
            end
        endcase
    end

    // An absolute value never comes out negative unless it overflowed.
    always_comb begin
        if (op == ALU_ABS && !ovf) begin
            AST_ABS_NONNEG: assert (!result[DATA_W-1]); // R2
        end
    end

endmodule

// File: rtl/dsp_flag_eval.sv
// Module: dsp_flag_eval
// Combinational flag generation from a finished result. The DC meaning is
// chosen per mode code through a generated decode table; every code of
// this block maps to carry/borrow meaning. Assumes MODE_W <= 4.
module dsp_flag_eval
    import dsp_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 40,
    parameter int unsigned MODE_W = 3,
    localparam int unsigned MODE_CNT = 1 << MODE_W
) (
    input  logic [DATA_W-1:0]   result,
    input  logic                bnd_carry,
    input  logic                ovf,
    input  logic [MODE_W-1:0]   mode,
    output dsp_flags_t          flags
);

    dc_meaning_e mode_table [MODE_CNT];
    dc_meaning_e meaning;

    // Build one decode entry per mode code; all select carry/borrow.
    for (genvar m = 0; m < MODE_CNT; m++) begin : g_mode
        assign mode_table[m] = DC_CARRY_BORROW;
    end

    // Look up the meaning of DC for the presented mode code.
    always_comb begin
        meaning = mode_table[mode];
    end

    // Derive each flag from the result and the side information.
    always_comb begin
        flags.n  = result[DATA_W-1];
        flags.z  = (result == '0);
        flags.v  = ovf;
        flags.gt = !result[DATA_W-1] && (result != '0);
        unique case (meaning)
            DC_CARRY_BORROW: flags.dc = bnd_carry;
            default:         flags.dc = bnd_carry;
        endcase
    end

endmodule

// File: rtl/dsp_status_reg.sv
// Module: dsp_status_reg
// Holds the five status flags. Loads new flags only when told to, holds
// otherwise, and clears on synchronous active-low reset.
module dsp_status_reg
    import dsp_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  dsp_flags_t  flags_d,
    output dsp_flags_t  flags_q
);

    logic past_ok;

    // Flag storage with a load enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (load) begin
            flags_q <= flags_d;
        end
    end

    // Marks that at least one cycle has passed since reset ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(load) |-> $stable(flags_q)); // R8

    AST_GT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.gt |-> !flags_q.n && !flags_q.z); // R6

endmodule

// File: rtl/dsp_flag_alu.sv
// Module: dsp_flag_alu (top)
// Guarded 40-bit DSP arithmetic unit. Registers the result with a one-cycle
// write strobe and keeps a status register whose update depends on whether
// the operation is conditional. Assumes inputs are stable around the edge.
module dsp_flag_alu
    import dsp_alu_pkg::*;
#(
    parameter int unsigned MAIN_W  = 32,
    parameter int unsigned GUARD_W = 8,
    parameter int unsigned MODE_W  = 3,
    localparam int unsigned DATA_W = MAIN_W + GUARD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          opcode,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                cond_op,
    input  logic                cond_true,
    input  logic [MODE_W-1:0]   dc_mode,
    output logic [DATA_W-1:0]   res,
    output logic                res_we,
    output logic                flag_dc,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_v,
    output logic                flag_gt
);

    alu_op_e           op_sel;
    logic [DATA_W-1:0] core_res;
    logic              core_carry;
    logic              core_ovf;
    dsp_flags_t        next_flags;
    dsp_flags_t        cur_flags;
    logic              do_write;
    logic              do_flags;
    logic              past_ok;

    // Decode the opcode and the write/flag qualifiers.
    always_comb begin
        op_sel   = alu_op_e'(opcode);
        do_write = op_valid && (!cond_op || cond_true);
        do_flags = op_valid && !cond_op;
    end

    dsp_alu_core #(
        .MAIN_W  (MAIN_W),
        .GUARD_W (GUARD_W)
    ) core_i (
        .op        (op_sel),
        .a         (opa),
        .b         (opb),
        .result    (core_res),
        .bnd_carry (core_carry),
        .ovf       (core_ovf)
    );

    dsp_flag_eval #(
        .DATA_W (DATA_W),
        .MODE_W (MODE_W)
    ) eval_i (
        .result    (core_res),
        .bnd_carry (core_carry),
        .ovf       (core_ovf),
        .mode      (dc_mode),
        .flags     (next_flags)
    );

    dsp_status_reg status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_flags),
        .flags_d (next_flags),
        .flags_q (cur_flags)
    );

    // Result register; loads only on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else if (do_write) begin
            res <= core_res;
        end
    end

    // Write strobe, high for the cycle after a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_we <= 1'b0;
        end else begin
            res_we <= do_write;
        end
    end

    // Marks that at least one cycle has passed since reset ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // Unpack the status record onto the flag ports.
    always_comb begin
        flag_dc = cur_flags.dc;
        flag_n  = cur_flags.n;
        flag_z  = cur_flags.z;
        flag_v  = cur_flags.v;
        flag_gt = cur_flags.gt;
    end

    AST_COND_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_valid && cond_op) |-> $stable(cur_flags)); // R9

    AST_FALSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_valid && cond_op && !cond_true) |-> !res_we && $stable(res)); // R10

    AST_ZN_TRACK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_valid && !cond_op) |-> (flag_z == (res == '0)) && (flag_n == res[DATA_W-1])); // R6

    AST_SMALL_ADD_NO_DC: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_valid && !cond_op && opcode == 2'b00 && !opa[MAIN_W-1] && !opb[MAIN_W-1]) |-> !flag_dc); // R3

    AST_WE_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> past_ok && $past(op_valid)); // R8

endmodule

// File: tb/dsp_flag_alu_tb_top.sv
// Bench for dsp_flag_alu: directed corner cases plus seeded random
// operations, compared against a reference model written from the brief.
module dsp_flag_alu_tb_top;

    localparam int unsigned DW = 40;
    localparam logic [63:0] FULL = 64'h00FF_FFFF_FFFF;
    localparam logic [63:0] MAIN = 64'h0000_FFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    opcode = 2'b00;
    logic [DW-1:0] opa = '0;
    logic [DW-1:0] opb = '0;
    logic          cond_op = 1'b0;
    logic          cond_true = 1'b0;
    logic [2:0]    dc_mode = 3'b000;
    logic [DW-1:0] res;
    logic          res_we;
    logic          flag_dc, flag_n, flag_z, flag_v, flag_gt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference state
    logic [DW-1:0] m_res = '0;
    logic [4:0]    m_flags = '0; // {dc,n,z,v,gt}

    always #2 clk = ~clk;

    dsp_flag_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .opa(opa), .opb(opb), .cond_op(cond_op), .cond_true(cond_true),
        .dc_mode(dc_mode), .res(res), .res_we(res_we), .flag_dc(flag_dc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_gt(flag_gt)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic longint sext(input logic [63:0] v);
        return v[39] ? longint'(v | 64'hFFFF_FF00_0000_0000) : longint'(v & FULL);
    endfunction

    // Reference computation of result, DC and V from the requirement text.
    task automatic ref_calc(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                            output logic [63:0] r, output logic dc, output logic v);
        longint t;
        logic [63:0] inv;
        a = a & FULL;
        b = b & FULL;
        inv = (~a) & FULL;
        case (op)
            2'b00: begin
                r  = (a + b) & FULL;
                dc = (((a & MAIN) + (b & MAIN)) >> 32) != 0;
                t  = sext(a) + sext(b);
            end
            2'b01: begin
                r  = (a - b) & FULL;
                dc = (a & MAIN) < (b & MAIN);
                t  = sext(a) - sext(b);
            end
            2'b10: begin
                r  = (inv + 1) & FULL;
                dc = (((inv & MAIN) + 1) >> 32) != 0;
                t  = -sext(a);
            end
            default: begin
                if (a[39]) begin
                    r  = (inv + 1) & FULL;
                    dc = (((inv & MAIN) + 1) >> 32) != 0;
                    t  = -sext(a);
                end else begin
                    r  = a;
                    dc = 1'b0;
                    t  = sext(a);
                end
            end
        endcase
        v = (t > 64'sh7F_FFFF_FFFF) || (t < -64'sh80_0000_0000);
    endtask

    // Apply one operation, then compare the ports with the model.
    task automatic run_op(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic c_op, input logic c_true, input logic [2:0] mode,
                          input string tag);
        logic [63:0] r;
        logic dc, v, wr, upd;
        ref_calc(op, {24'd0, a}, {24'd0, b}, r, dc, v);
        wr  = !c_op || c_true;
        upd = !c_op;
        if (wr) m_res = r[DW-1:0];
        if (upd) m_flags = {dc, r[39], r[39:0] == 0, v, !r[39] && r[39:0] != 0};
        @(negedge clk);
        op_valid = 1'b1; opcode = op; opa = a; opb = b;
        cond_op = c_op; cond_true = c_true; dc_mode = mode;
        @(negedge clk);
        op_valid = 1'b0;
        check({tag, " write strobe R8/R9/R10"}, {63'd0, res_we}, {63'd0, wr});
        check({tag, " result R1/R2"}, {24'd0, res}, {24'd0, m_res});
        check({tag, " DC R3/R4/R5/R12"}, {63'd0, flag_dc}, {63'd0, m_flags[4]});
        check({tag, " N/Z/GT R6"}, {61'd0, flag_n, flag_z, flag_gt},
              {61'd0, m_flags[3], m_flags[2], m_flags[0]});
        check({tag, " V R7"}, {63'd0, flag_v}, {63'd0, m_flags[1]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("reset res R11", {24'd0, res}, 64'd0);
        check("reset strobe R11", {63'd0, res_we}, 64'd0);
        check("reset flags R11", {59'd0, flag_dc, flag_n, flag_z, flag_v, flag_gt}, 64'd0);

        // R3: main-part carry into bit 32 sets DC
        run_op(2'b00, 40'h00_FFFF_FFFF, 40'h00_0000_0001, 0, 0, 3'b000, "R3 boundary carry");
        // R3: carry out of guard only leaves DC clear
        run_op(2'b00, 40'hFF_0000_0000, 40'h01_0000_0000, 0, 0, 3'b000, "R3 guard-only carry");
        // R4: no borrow
        run_op(2'b01, 40'h00_0000_0011, 40'h00_0000_0001, 0, 0, 3'b000, "R4 no borrow");
        // R4: borrow
        run_op(2'b01, 40'h00_0000_0001, 40'h00_0000_0002, 0, 0, 3'b000, "R4 borrow");
        // R5: negate of zero main part carries; abs negative; abs positive
        run_op(2'b10, 40'h00_0000_0000, 40'h0, 0, 0, 3'b000, "R5 neg zero");
        run_op(2'b10, 40'hFE_0000_0000, 40'h0, 0, 0, 3'b000, "R5 neg zero main");
        run_op(2'b11, 40'hFF_FFFF_FFF0, 40'h0, 0, 0, 3'b000, "R5 abs negative");
        run_op(2'b11, 40'h12_3456_7890, 40'h0, 0, 0, 3'b000, "R5 abs positive");
        // R2/R7: most negative value
        run_op(2'b11, 40'h80_0000_0000, 40'h0, 0, 0, 3'b000, "R2 R7 abs most-neg");
        run_op(2'b10, 40'h80_0000_0000, 40'h0, 0, 0, 3'b000, "R7 neg most-neg");
        run_op(2'b00, 40'h7F_FFFF_FFFF, 40'h00_0000_0001, 0, 0, 3'b000, "R7 add overflow");
        // R9: conditional true writes, flags kept
        run_op(2'b00, 40'h00_FFFF_FFFF, 40'h00_0000_0001, 0, 0, 3'b000, "R8 set flags");
        run_op(2'b01, 40'h00_0000_0005, 40'h00_0000_0005, 1, 1, 3'b000, "R9 cond true");
        // R10: conditional false: no write, flags kept
        run_op(2'b10, 40'h00_0000_0007, 40'h0, 1, 0, 3'b000, "R10 cond false");
        // R12: other mode codes still carry/borrow
        for (int m = 1; m < 8; m++) begin
            run_op(2'b00, 40'h00_8000_0000, 40'h00_8000_0000, 0, 0, 3'(m), "R12 mode carry");
            run_op(2'b01, 40'h00_0000_0000, 40'h00_0000_0001, 0, 0, 3'(m), "R12 mode borrow");
        end
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [DW-1:0] a, b;
            logic [1:0] op;
            logic co, ct;
            a  = {8'($urandom), 32'($urandom)};
            b  = {8'($urandom), 32'($urandom)};
            if ($urandom % 4 == 0) a[31:0] = '0;
            if ($urandom % 4 == 0) a[39:32] = {8{a[31]}};
            op = 2'($urandom);
            co = ($urandom % 3 == 0);
            ct = 1'($urandom);
            run_op(op, a, b, co, ct, 3'($urandom), "R1 random");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule